// File: doc/BRIEF.md
# NAND Completion Waiter

This block waits for a raw NAND flash device to finish a program, erase, read or reset operation after a command engine has issued it. The engine pulses `start_i` and says whether the finished command was a device reset. A static configuration input says whether the device's ready/busy line is wired. When the line is present, the block watches it. When it is absent, the block polls the status register and watches its READY bit instead.

A normal wait first holds off for a short guard interval, which covers the device's write-to-busy time. It then sends one STATUS command on the command port and polls until the device is ready or the wait times out. A reset on a device with no ready/busy line works differently: the block waits a configured chip delay, then sends STATUS and polls status with a separate, shorter timeout. Every wait ends with one last status read. That byte is reported together with a timeout flag and an error flag, and a one-cycle done pulse marks the end.

Top module: `nand_rdy_waiter`

## Requirements
- R1: Out of reset, `done_o`, `cmd_req_o` and `st_req_o` are low.
- R2: After an accepted normal start, `cmd_req_o` does not rise until at least GUARD_CYC cycles have passed. GUARD_CYC is GUARD_NS converted with CYC_PER_US, rounded up, and is at least 1.
- R3: Each wait sends exactly one command, code STATUS_OP (0x70) on `cmd_code_o`. `cmd_req_o` stays high until `cmd_ack_i`, and no status read happens before that command is accepted.
- R4: In pin mode (`rb_present_i`=1 at start), the block ends polling once `rb_i` is high. It performs exactly one status read, the final one, and no other.
- R5: In status mode, the block repeats status reads (`st_req_o` held high, one transfer per cycle with `st_ack_i`) until a byte has bit RDY_BIT (6) set. It then performs one more final read. `rb_i` has no effect in this mode.
- R6: At `done_o`, `status_o` holds the final byte and `timeout_o` is the inverse of that byte's bit RDY_BIT.
- R7: A normal wait gives up no earlier than NORM_TMO_US microseconds (CYC_PER_US cycles each) after the guard interval ends. It then does the final read.
- R8: A start with `reset_op_i`=1 and `rb_present_i`=0 skips the guard. It waits CHIP_DLY_US microseconds before the command, then polls status with a RST_TMO_US microsecond limit.
- R9: A start with `reset_op_i`=1 and `rb_present_i`=1 behaves like a normal pin-mode wait.
- R10: A status transfer with `st_err_i` high ends the wait at once. The block reports `error_o`=1, `status_o`=0 and `timeout_o`=0.
- R11: `done_o` is a one-cycle pulse. A `start_i` that arrives while a wait is in progress is ignored, including its mode inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a wait (sampled only when idle) |
| reset_op_i | input | 1 | The command being waited on was a device reset |
| rb_present_i | input | 1 | Ready/busy line is wired |
| rb_i | input | 1 | Ready/busy line, high = ready (asynchronous) |
| cmd_req_o | output | 1 | Command latch request |
| cmd_code_o | output | 8 | Command byte to latch |
| cmd_ack_i | input | 1 | Command accepted this cycle |
| st_req_o | output | 1 | Status byte read request |
| st_ack_i | input | 1 | Status byte delivered this cycle |
| st_err_i | input | 1 | Status read failed (valid with ack) |
| st_byte_i | input | 8 | Status byte (valid with ack) |
| done_o | output | 1 | Wait finished, one cycle |
| status_o | output | 8 | Final status byte |
| timeout_o | output | 1 | Final byte not ready |
| error_o | output | 1 | Wait ended by a failed status read |

## Verification
The bench builds the block with 20 cycles per microsecond, a 100 ns guard (2 cycles), a 10 us normal limit, a 6 us reset limit and a 2 us chip delay. With these values each timeout lasts only a few hundred cycles, so both timeout paths, the chip delay before the reset-path command and the guard spacing can be measured directly in cycle counts. A device model with random acknowledge stalls, random status bits and injectable read errors covers every mode.

// File: rtl/nrw_pkg.sv
package nrw_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_GUARD, W_CHIPDLY, W_CMD, W_PINPOLL, W_STPOLL, W_FINAL, W_DONE
  } wait_st_e;
endpackage

// File: rtl/nrw_tick_gen.sv
// Microsecond tick prescaler, restarted by clr_i.
module nrw_tick_gen #(
  parameter int CYC_PER_US = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    if (clr_i)            pre_d = '0;
    else if (pre_q == LAST) pre_d = '0;
    else                  pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = !clr_i && (pre_q == LAST);
endmodule

// File: rtl/nrw_us_timer.sv
// Microsecond counter with a limit captured at load; sticky expiry.
module nrw_us_timer #(
  parameter int TW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] limit_i,
  input  logic          tick_i,
  output logic          exp_o
);
  logic [TW-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic          exp_q, exp_d;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    exp_d = exp_q;
    if (load_i) begin
      cnt_d = '0;
      lim_d = limit_i;
      exp_d = (limit_i == '0);
    end else if (tick_i && !exp_q) begin
      cnt_d = cnt_q + TW'(1);
      if (cnt_q + TW'(1) >= lim_q) exp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      exp_q <= exp_d;
    end
  end

  assign exp_o = exp_q;
endmodule

// File: rtl/nrw_guard_cnt.sv
// Post-command guard interval in clock cycles.
module nrw_guard_cnt #(
  parameter int GUARD_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic done_o
);
  localparam int GW = $clog2(GUARD_CYC + 1);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = GW'(GUARD_CYC);
    else        cnt_d = cnt_q - GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/nrw_fsm.sv
// Sequencer: guard or chip delay, STATUS command, poll, final read.
module nrw_fsm
  import nrw_pkg::*;
#(
  parameter int TW          = 19,
  parameter int RDY_BIT     = 6,
  parameter int NORM_TMO_US = 400000,
  parameter int RST_TMO_US  = 250000,
  parameter int CHIP_DLY_US = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          reset_op_i,
  input  logic          rb_present_i,
  input  logic          rb_ready_i,
  input  logic          cmd_ack_i,
  input  logic          st_ack_i,
  input  logic          st_err_i,
  input  logic [7:0]    st_byte_i,
  input  logic          guard_done_i,
  input  logic          tmr_exp_i,
  output logic          guard_load_o,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_limit_o,
  output logic          cmd_req_o,
  output logic          st_req_o,
  output logic          done_o,
  output logic [7:0]    status_o,
  output logic          timeout_o,
  output logic          error_o
);
  wait_st_e   st_q, st_d;
  logic       pin_q, pin_d;
  logic       mode_en;
  logic       res_en;
  logic [7:0] res_st_d, res_st_q;
  logic       res_tmo_d, res_tmo_q;
  logic       res_err_d, res_err_q;

  always_comb begin
    st_d         = st_q;
    pin_d        = pin_q;
    mode_en      = 1'b0;
    guard_load_o = 1'b0;
    tmr_load_o   = 1'b0;
    tmr_limit_o  = '0;
    res_en       = 1'b0;
    res_st_d     = st_byte_i;
    res_tmo_d    = !st_byte_i[RDY_BIT];
    res_err_d    = 1'b0;
    unique case (st_q)
      W_IDLE: begin
        if (start_i) begin
          mode_en = 1'b1;
          pin_d   = rb_present_i;
          if (reset_op_i && !rb_present_i) begin
            st_d        = W_CHIPDLY;
            tmr_load_o  = 1'b1;
            tmr_limit_o = TW'(CHIP_DLY_US);
          end else begin
            st_d         = W_GUARD;
            guard_load_o = 1'b1;
          end
        end
      end
      W_GUARD: begin
        if (guard_done_i) begin
          st_d        = W_CMD;
          tmr_load_o  = 1'b1;
          tmr_limit_o = TW'(NORM_TMO_US);
        end
      end
      W_CHIPDLY: begin
        if (tmr_exp_i) begin
          st_d        = W_CMD;
          tmr_load_o  = 1'b1;
          tmr_limit_o = TW'(RST_TMO_US);
        end
      end
      W_CMD: begin
        if (cmd_ack_i) st_d = pin_q ? W_PINPOLL : W_STPOLL;
      end
      W_PINPOLL: begin
        if (rb_ready_i || tmr_exp_i) st_d = W_FINAL;
      end
      W_STPOLL: begin
        if (st_ack_i) begin
          if (st_err_i) begin
            st_d      = W_DONE;
            res_en    = 1'b1;
            res_st_d  = '0;
            res_tmo_d = 1'b0;
            res_err_d = 1'b1;
          end else if (st_byte_i[RDY_BIT] || tmr_exp_i) begin
            st_d = W_FINAL;
          end
        end
      end
      W_FINAL: begin
        if (st_ack_i) begin
          st_d   = W_DONE;
          res_en = 1'b1;
          if (st_err_i) begin
            res_st_d  = '0;
            res_tmo_d = 1'b0;
            res_err_d = 1'b1;
          end
        end
      end
      W_DONE:  st_d = W_IDLE;
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= W_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pin_q <= 1'b0;
    else if (mode_en) pin_q <= pin_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_st_q  <= '0;
      res_tmo_q <= 1'b0;
      res_err_q <= 1'b0;
    end else if (res_en) begin
      res_st_q  <= res_st_d;
      res_tmo_q <= res_tmo_d;
      res_err_q <= res_err_d;
    end
  end

  assign cmd_req_o = (st_q == W_CMD);
  assign st_req_o  = (st_q == W_STPOLL) || (st_q == W_FINAL);
  assign done_o    = (st_q == W_DONE);
  assign status_o  = res_st_q;
  assign timeout_o = res_tmo_q;
  assign error_o   = res_err_q;
endmodule

// File: rtl/nand_rdy_waiter.sv
module nand_rdy_waiter #(
  parameter int          CYC_PER_US  = 250,
  parameter int          GUARD_NS    = 100,
  parameter int          NORM_TMO_US = 400000,
  parameter int          RST_TMO_US  = 250000,
  parameter int          CHIP_DLY_US = 20,
  parameter int          RDY_BIT     = 6,
  parameter logic [7:0]  STATUS_OP   = 8'h70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       reset_op_i,
  input  logic       rb_present_i,
  input  logic       rb_i,
  output logic       cmd_req_o,
  output logic [7:0] cmd_code_o,
  input  logic       cmd_ack_i,
  output logic       st_req_o,
  input  logic       st_ack_i,
  input  logic       st_err_i,
  input  logic [7:0] st_byte_i,
  output logic       done_o,
  output logic [7:0] status_o,
  output logic       timeout_o,
  output logic       error_o
);
  localparam int GUARD_RAW = (CYC_PER_US * GUARD_NS + 999) / 1000;
  localparam int GUARD_CYC = (GUARD_RAW < 1) ? 1 : GUARD_RAW;
  localparam int MAX_A     = (NORM_TMO_US > RST_TMO_US) ? NORM_TMO_US : RST_TMO_US;
  localparam int MAX_US    = (MAX_A > CHIP_DLY_US) ? MAX_A : CHIP_DLY_US;
  localparam int TW        = $clog2(MAX_US + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [1:0]    rb_sync_q;
  logic          tick;
  logic          tmr_load;
  logic [TW-1:0] tmr_limit;
  logic          tmr_exp;
  logic          guard_load;
  logic          guard_done;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // ready/busy line crosses in from the pad
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rb_sync_q <= 2'b00;
    else            rb_sync_q <= {rb_sync_q[0], rb_i};
  end

  nrw_tick_gen #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (tmr_load),
    .tick_o (tick)
  );

  nrw_us_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (tmr_load),
    .limit_i (tmr_limit),
    .tick_i  (tick),
    .exp_o   (tmr_exp)
  );

  nrw_guard_cnt #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (guard_load),
    .done_o (guard_done)
  );

  nrw_fsm #(
    .TW          (TW),
    .RDY_BIT     (RDY_BIT),
    .NORM_TMO_US (NORM_TMO_US),
    .RST_TMO_US  (RST_TMO_US),
    .CHIP_DLY_US (CHIP_DLY_US)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start_i),
    .reset_op_i   (reset_op_i),
    .rb_present_i (rb_present_i),
    .rb_ready_i   (rb_sync_q[1]),
    .cmd_ack_i    (cmd_ack_i),
    .st_ack_i     (st_ack_i),
    .st_err_i     (st_err_i),
    .st_byte_i    (st_byte_i),
    .guard_done_i (guard_done),
    .tmr_exp_i    (tmr_exp),
    .guard_load_o (guard_load),
    .tmr_load_o   (tmr_load),
    .tmr_limit_o  (tmr_limit),
    .cmd_req_o    (cmd_req_o),
    .st_req_o     (st_req_o),
    .done_o       (done_o),
    .status_o     (status_o),
    .timeout_o    (timeout_o),
    .error_o      (error_o)
  );

  assign cmd_code_o = STATUS_OP;
endmodule

// File: rtl/nrw_waiter_chk.sv
module nrw_waiter_chk #(
  parameter int RDY_BIT = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_req_o,
  input logic       cmd_ack_i,
  input logic       st_req_o,
  input logic       st_ack_i,
  input logic       st_err_i,
  input logic       done_o,
  input logic [7:0] status_o,
  input logic       timeout_o,
  input logic       error_o
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_req_o && st_req_o)); // R3
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && !cmd_ack_i |=> cmd_req_o); // R3
  AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    st_req_o && !st_ack_i |=> st_req_o); // R5
  AST_TMO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !error_o |-> (timeout_o == !status_o[RDY_BIT])); // R6
  AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && error_o |-> (status_o == 8'h00) && !timeout_o); // R10
  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    st_req_o && st_ack_i && st_err_i |=> done_o); // R10
endmodule

bind nand_rdy_waiter nrw_waiter_chk #(.RDY_BIT(RDY_BIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_req_o (cmd_req_o),
  .cmd_ack_i (cmd_ack_i),
  .st_req_o  (st_req_o),
  .st_ack_i  (st_ack_i),
  .st_err_i  (st_err_i),
  .done_o    (done_o),
  .status_o  (status_o),
  .timeout_o (timeout_o),
  .error_o   (error_o)
);

// File: tb/nand_rdy_waiter_test.sv
`timescale 1ns/1ps
module nand_rdy_waiter_test;
  localparam int CPU  = 20;
  localparam int GNS  = 100;
  localparam int NT   = 10;
  localparam int RT   = 6;
  localparam int CD   = 2;
  localparam int G    = (CPU * GNS + 999) / 1000;
  localparam int TO_N = G + 1 + NT * CPU;
  localparam int TO_R = CD * CPU + 1 + RT * CPU;
  localparam int NEVER = 1000000;

  logic clk, rst_n, start, reset_op, rb_present, rb;
  logic cmd_req, cmd_ack, st_req, st_ack, st_err, done, tmo, err;
  logic [7:0] cmd_code, st_byte, status;

  nand_rdy_waiter #(
    .CYC_PER_US(CPU), .GUARD_NS(GNS), .NORM_TMO_US(NT),
    .RST_TMO_US(RT), .CHIP_DLY_US(CD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .reset_op_i(reset_op),
    .rb_present_i(rb_present), .rb_i(rb), .cmd_req_o(cmd_req),
    .cmd_code_o(cmd_code), .cmd_ack_i(cmd_ack), .st_req_o(st_req),
    .st_ack_i(st_ack), .st_err_i(st_err), .st_byte_i(st_byte),
    .done_o(done), .status_o(status), .timeout_o(tmo), .error_o(err)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, start_cyc = 0;
  int m_rdy = 0, m_rbd = 0, m_err = -1;
  bit m_pin = 0;
  int st_idx = 0, cmd_cnt = 0, order_bad = 0, done_cnt = 0, done_cyc = 0;
  int first_cmd = 0;
  bit cmd_seen = 0;
  bit last_err = 0;
  logic [7:0] last_byte = 8'h00;
  logic [7:0] last_code = 8'h00;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // device model: decides acks at each falling edge; transfers land on the next rising edge
  initial begin
    cmd_ack = 0; st_ack = 0; st_err = 0; st_byte = 8'h00; rb = 0;
    forever begin
      @(negedge clk);
      cyc++;
      rb = (m_rbd >= 0) && (cyc - start_cyc >= m_rbd);
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (cmd_req && !cmd_seen) begin cmd_seen = 1; first_cmd = cyc; end
      cmd_ack = cmd_req && ($urandom_range(0, 3) != 0);
      if (cmd_ack) begin cmd_cnt++; last_code = cmd_code; end
      st_ack = st_req && ($urandom_range(0, 3) != 0);
      st_err = 0;
      st_byte = 8'($urandom);
      if (st_ack) begin
        st_byte[6] = m_pin ? rb : (st_idx >= m_rdy);
        st_err = (st_idx == m_err);
        if (cmd_cnt == 0) order_bad++;
        last_byte = st_byte;
        last_err = st_err;
        st_idx++;
      end
    end
  end

  initial begin
    wait (cyc > 150000);
    chk(0, "watchdog expired", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic run_op(input bit rop, input bit pin, input int rdy_a, input int rbd,
                        input int err_a, input bit again,
                        input int lat_lo, input int lat_hi,
                        input int cmd_lo, input int cmd_hi,
                        input int exp_reads, input bit exp_err, input string rq);
    int lat, cdel;
    bit exp_tmo;
    logic [7:0] exp_st;
    @(negedge clk); #1;
    m_pin = pin; m_rdy = rdy_a; m_err = err_a;
    st_idx = 0; cmd_cnt = 0; order_bad = 0; done_cnt = 0; cmd_seen = 0;
    start_cyc = cyc;
    m_rbd = rbd;
    reset_op = rop; rb_present = pin; start = 1;
    @(negedge clk); #1;
    start = 0;
    if (again) begin
      repeat (8) @(negedge clk);
      #1;
      reset_op = !rop; rb_present = !pin; start = 1;
      @(negedge clk); #1;
      start = 0;
    end
    while (done_cnt == 0 && cyc - start_cyc < 3000) @(negedge clk);
    repeat (6) @(negedge clk);
    #1;
    lat  = done_cyc - start_cyc;
    cdel = first_cmd - start_cyc;
    chk(done_cnt == 1, {rq, " R11 single done pulse"}, done_cnt, 1);
    chk(lat >= lat_lo && lat <= lat_hi, {rq, " R7 wait length"}, lat, lat_lo);
    chk(cdel >= cmd_lo && cdel <= cmd_hi, {rq, " R2 command spacing"}, cdel, cmd_lo);
    chk(cmd_cnt == 1 && order_bad == 0 && last_code == 8'h70,
        {rq, " R3 one status command first"}, cmd_cnt * 1000 + order_bad, 1000);
    if (exp_reads >= 0)
      chk(st_idx == exp_reads, {rq, " status read count"}, st_idx, exp_reads);
    chk(err == exp_err, {rq, " R10 error flag"}, err, exp_err);
    exp_st  = exp_err ? 8'h00 : last_byte;
    exp_tmo = exp_err ? 1'b0 : !last_byte[6];
    chk(status == exp_st, {rq, " R6 status byte"}, status, exp_st);
    chk(tmo == exp_tmo, {rq, " R6 timeout flag"}, tmo, exp_tmo);
  endtask

  function automatic int exp_reads_f(input bit pin, input int rdy_a);
    return pin ? 1 : rdy_a + 2;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; start = 0; reset_op = 0; rb_present = 0;
    repeat (3) @(negedge clk);
    chk(done == 0 && cmd_req == 0 && st_req == 0, "R1 reset outputs", {done, cmd_req, st_req}, 0);
    #1 rst_n = 1;
    repeat (5) @(negedge clk);
    chk(done == 0 && cmd_req == 0 && st_req == 0, "R1 idle after reset", {done, cmd_req, st_req}, 0);

    // status mode, ready on the first poll; rb held high must not matter (R5)
    run_op(0, 0, 0, 0, -1, 0, 1, TO_N - 1, G + 1, G + 3, 2, 0, "R5");
    // status mode, ready after several polls
    run_op(0, 0, 4, 0, -1, 0, 1, TO_N - 1, G + 1, G + 3, 6, 0, "R5");
    // pin mode, line rises later
    run_op(0, 1, NEVER, 30, -1, 0, 30, TO_N - 1, G + 1, G + 3, 1, 0, "R4");
    // pin mode, line never rises: timeout
    run_op(0, 1, NEVER, -1, -1, 0, TO_N, TO_N + 40, G + 1, G + 3, 1, 0, "R7");
    // status mode, never ready: timeout
    run_op(0, 0, NEVER, 0, -1, 0, TO_N, TO_N + 40, G + 1, G + 3, -1, 0, "R7");
    // reset without pin: chip delay then status polling
    run_op(1, 0, 2, 0, -1, 0, CD * CPU, TO_R - 1, CD * CPU + 1, CD * CPU + 3, 4, 0, "R8");
    // reset without pin, never ready: shorter limit
    run_op(1, 0, NEVER, 0, -1, 0, TO_R, TO_R + 40, CD * CPU + 1, CD * CPU + 3, -1, 0, "R8");
    // reset with pin behaves as a normal pin wait
    run_op(1, 1, NEVER, 20, -1, 0, 20, TO_N - 1, G + 1, G + 3, 1, 0, "R9");
    // failed poll read ends at once
    run_op(0, 0, NEVER, 0, 2, 0, 1, TO_N - 1, G + 1, G + 3, 3, 1, "R10");
    // failed final read in pin mode
    run_op(0, 1, NEVER, 10, 0, 0, 10, TO_N - 1, G + 1, G + 3, 1, 1, "R10");
    // second start during a wait is ignored
    run_op(0, 0, 3, 0, -1, 1, 1, TO_N - 1, G + 1, G + 3, 5, 0, "R11");

    for (int i = 0; i < 20; i++) begin
      bit rop, pin, nopin_rst;
      int ra, rd;
      rop = 1'($urandom);
      pin = 1'($urandom);
      ra  = $urandom_range(0, 6);
      rd  = $urandom_range(5, 60);
      nopin_rst = rop && !pin;
      run_op(rop, pin, pin ? NEVER : ra, pin ? rd : 0, -1, 0,
             1, (nopin_rst ? TO_R : TO_N) - 1,
             nopin_rst ? CD * CPU + 1 : G + 1, nopin_rst ? CD * CPU + 3 : G + 3,
             exp_reads_f(pin, ra), 0, pin ? "R4" : "R5");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule